// File: doc/BRIEF.md
# Atomic Swap Memory Access Unit

This block sits in front of a single-port word RAM and serves memory requests one at a time. Each request names a command (read, write, swap, conditional swap or invalidate), a byte address, an access size of 1, 2, 4 or 8 bytes, write data, a compare value, a requester number and a few flags. Reads return the addressed bytes. Writes are first offered to an external reservation monitor, which decides whether they may proceed. Swaps exchange a memory value for new data atomically. A conditional swap writes only when the stored value matches the compare value.

A swap is a read-modify-write. The RAM is read in the accept cycle, and in the following cycle the unit compares the old value, writes the new value and answers the request. During that second cycle the unit lowers its ready signal. Every other command takes a single cycle. A response, when one is requested, always appears in the cycle after acceptance. Per-requester counters record reads, writes and other operations, together with the number of bytes read and written. A read flagged as load-linked reports its requester and address so that a reservation can be set.

Top module: `swap_mem_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, err_cmd is 0 and every counter is 0.
- R2: A read (command 0) returns rsp_data in the cycle after acceptance. rsp_data holds the 2^size bytes at the address, little-endian and zero-extended, where size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes. The requester's read count rises by 1 and its read byte total rises by the size.
- R3: A read accepted with req_ll set raises ll_valid in its accept cycle, with ll_id and ll_addr equal to the request's requester and address. No other command raises ll_valid.
- R4: A write (command 1) raises wr_chk_valid in its accept cycle, with the request's address and requester. Memory is changed only if wr_chk_ok is 1, and then only the bytes within the size. The write count and write byte total rise only when the write is performed.
- R5: A swap (command 2) returns the old value, stores the new data, and holds req_ready at 0 for exactly the one cycle after acceptance. The requester's other-operation count rises by 1.
- R6: A conditional swap (command 3) with size 4 or 8 bytes returns the old value in every case. It stores the new data only when the old value equals the low size bytes of req_cmp. It stalls like a swap and counts as an other operation.
- R7: A conditional swap with a 1- or 2-byte size responds with rsp_err 1 and data 0. It changes no memory, causes no stall and updates no counter.
- R8: A request accepted with req_inhibit set produces no response, no memory change, no counter update, no wr_chk_valid and no ll_valid.
- R9: An invalidate (command 4) changes no memory and no counter, and it responds with data 0 when a response is requested.
- R10: A command code of 5, 6 or 7 sets err_cmd, which stays set until reset. Such a request produces no memory write and no response.
- R11: rsp_valid is raised only for an accepted, non-inhibited, legal request that had req_need_rsp set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_cmd | input | 3 | 0 read, 1 write, 2 swap, 3 conditional swap, 4 invalidate |
| req_id | input | IDW (2) | Requester number |
| req_addr | input | AW (9) | Byte address, aligned to the size |
| req_size | input | 2 | Size code, meaning 2^code bytes |
| req_wdata | input | 64 | Write or swap data, in the low bytes |
| req_cmp | input | 64 | Compare value for a conditional swap |
| req_inhibit | input | 1 | Drop the request entirely |
| req_need_rsp | input | 1 | Request wants a response |
| req_ll | input | 1 | Read is load-linked |
| rsp_valid | output | 1 | Response flag |
| rsp_data | output | 64 | Old or read data, zero-extended |
| rsp_err | output | 1 | Conditional swap had an illegal size |
| err_cmd | output | 1 | Sticky flag for an unknown command |
| wr_chk_valid | output | 1 | Ask the monitor about a write |
| wr_chk_id | output | IDW (2) | Requester of the write |
| wr_chk_addr | output | AW (9) | Address of the write |
| wr_chk_ok | input | 1 | Monitor allows the write |
| ll_valid | output | 1 | Register a reservation |
| ll_id | output | IDW (2) | Requester of the load-linked read |
| ll_addr | output | AW (9) | Address of the load-linked read |
| cnt_rd | output | NREQ*CW (64) | Read counts, one CW-bit field per requester |
| cnt_wr | output | NREQ*CW (64) | Performed write counts |
| cnt_oth | output | NREQ*CW (64) | Swap and conditional swap counts |
| byt_rd | output | NREQ*BW (80) | Bytes read per requester |
| byt_wr | output | NREQ*BW (80) | Bytes written per requester |

## Verification
The assertions watch the handshake and flag rules on every cycle. They check the one-cycle stall after a read-modify-write and the return of ready after it. They also check that responses come only from accepted, non-inhibited requests that asked for one, that inhibited requests never reach the monitor or raise the load-linked pulse, that a short conditional swap reports an error, and that the command error stays set. Data values, byte placement within a word, the compare decision of a conditional swap, the effect of a monitor refusal and the counter totals can only be shown by the bench. It replays directed corner cases and random traffic against a byte-level memory model, reading locations back after each kind of write.

// File: rtl/smu_pkg.sv
`timescale 1ns/1ps
package smu_pkg;

  localparam int DW    = 64;
  localparam int LANES = DW / 8;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_SWAP  = 3'd2,
    CMD_CSWAP = 3'd3,
    CMD_INVAL = 3'd4
  } smu_cmd_e;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_SWAP, K_CSWAP, K_BADSZ, K_INVAL
  } smu_kind_e;

  // number of bytes for a size code
  function automatic logic [3:0] size_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // value mask covering the low bytes of a size code
  function automatic logic [DW-1:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  // byte enables for an access at a lane offset
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] s,
                                                 input logic [2:0] off);
    logic [LANES-1:0] m;
    case (s)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m << off;
  endfunction

  // bring the addressed bytes of a word down to bit 0
  function automatic logic [DW-1:0] pick(input logic [DW-1:0] word,
                                         input logic [1:0] s,
                                         input logic [2:0] off);
    return (word >> {off, 3'b000}) & size_mask(s);
  endfunction

  // move low-order data up to its lane offset
  function automatic logic [DW-1:0] place(input logic [DW-1:0] data,
                                          input logic [2:0] off);
    return data << {off, 3'b000};
  endfunction

endpackage

// File: rtl/smu_ram.sv
`timescale 1ns/1ps
module smu_ram #(
  parameter int IDXW  = 6,
  parameter int LANES = 8
) (
  input  logic                 clk,
  input  logic                 re,
  input  logic [IDXW-1:0]      raddr,
  output logic [LANES*8-1:0]   rdata,
  input  logic                 we,
  input  logic [IDXW-1:0]      waddr,
  input  logic [LANES-1:0]     wbe,
  input  logic [LANES*8-1:0]   wdata
);
  localparam int WORDS = 1 << IDXW;

  logic [LANES*8-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (we && wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/smu_counters.sv
`timescale 1ns/1ps
module smu_counters #(
  parameter int NREQ = 4,
  parameter int IDW  = 2,
  parameter int CW   = 16,
  parameter int BW   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_rd,
  input  logic               inc_wr,
  input  logic               inc_oth,
  input  logic [IDW-1:0]     id,
  input  logic [3:0]         nbytes,
  output logic [NREQ*CW-1:0] cnt_rd,
  output logic [NREQ*CW-1:0] cnt_wr,
  output logic [NREQ*CW-1:0] cnt_oth,
  output logic [NREQ*BW-1:0] byt_rd,
  output logic [NREQ*BW-1:0] byt_wr
);
  logic [BW-1:0] nb_ext;
  assign nb_ext = {{(BW-4){1'b0}}, nbytes};

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    logic mine;
    assign mine = (id == IDW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_rd[g*CW +: CW]  <= '0;
        cnt_wr[g*CW +: CW]  <= '0;
        cnt_oth[g*CW +: CW] <= '0;
        byt_rd[g*BW +: BW]  <= '0;
        byt_wr[g*BW +: BW]  <= '0;
      end else if (mine) begin
        if (inc_rd) begin
          cnt_rd[g*CW +: CW] <= cnt_rd[g*CW +: CW] + 1'b1;
          byt_rd[g*BW +: BW] <= byt_rd[g*BW +: BW] + nb_ext;
        end
        if (inc_wr) begin
          cnt_wr[g*CW +: CW] <= cnt_wr[g*CW +: CW] + 1'b1;
          byt_wr[g*BW +: BW] <= byt_wr[g*BW +: BW] + nb_ext;
        end
        if (inc_oth) cnt_oth[g*CW +: CW] <= cnt_oth[g*CW +: CW] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smu_ctrl.sv
`timescale 1ns/1ps
module smu_ctrl
  import smu_pkg::*;
#(
  parameter int AW   = 9,
  parameter int IDXW = AW - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_cmd,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    req_cmp,
  input  logic             req_inhibit,
  input  logic             req_need_rsp,
  input  logic             req_ll,
  input  logic             wr_chk_ok,
  output logic             wr_chk_valid,
  output logic             ll_valid,
  output logic             ram_re,
  output logic [IDXW-1:0]  ram_raddr,
  input  logic [DW-1:0]    ram_q,
  output logic             ram_we,
  output logic [IDXW-1:0]  ram_waddr,
  output logic [LANES-1:0] ram_wbe,
  output logic [DW-1:0]    ram_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_err,
  output logic             err_cmd,
  output logic             acc,
  output logic             ev_rd,
  output logic             ev_wr,
  output logic             ev_oth
);
  // request decode
  logic            live, is_rd, is_wr, is_sw, cs_ok, cs_bad, is_inv, is_bad;
  logic            wr_go;
  logic [IDXW-1:0] r_word;
  logic [2:0]      r_off;
  smu_kind_e       nxt_kind;

  // stage holding the accepted request for one cycle
  smu_kind_e       p_kind;
  logic            p_rsp;
  logic [IDXW-1:0] p_word;
  logic [2:0]      p_off;
  logic [1:0]      p_size;
  logic [DW-1:0]   p_wdata;
  logic [DW-1:0]   p_cmp;

  // read-modify-write step
  logic            in_rmw, cmp_hit, rmw_wr;
  logic [DW-1:0]   old_val;

  assign r_word = req_addr[AW-1:3];
  assign r_off  = req_addr[2:0];

  assign in_rmw    = (p_kind == K_SWAP) || (p_kind == K_CSWAP);
  assign req_ready = !in_rmw;
  assign acc       = req_valid && req_ready;
  assign live      = acc && !req_inhibit;

  assign is_rd  = live && (req_cmd == CMD_READ);
  assign is_wr  = live && (req_cmd == CMD_WRITE);
  assign is_sw  = live && (req_cmd == CMD_SWAP);
  assign cs_ok  = live && (req_cmd == CMD_CSWAP) && req_size[1];
  assign cs_bad = live && (req_cmd == CMD_CSWAP) && !req_size[1];
  assign is_inv = live && (req_cmd == CMD_INVAL);
  assign is_bad = live && (req_cmd > CMD_INVAL);

  assign wr_chk_valid = is_wr;
  assign wr_go        = is_wr && wr_chk_ok;
  assign ll_valid     = is_rd && req_ll;

  assign ev_rd  = is_rd;
  assign ev_wr  = wr_go;
  assign ev_oth = is_sw || cs_ok;

  always_comb begin
    nxt_kind = K_NONE;
    if (is_rd)  nxt_kind = K_READ;
    if (is_wr)  nxt_kind = K_WRITE;
    if (is_sw)  nxt_kind = K_SWAP;
    if (cs_ok)  nxt_kind = K_CSWAP;
    if (cs_bad) nxt_kind = K_BADSZ;
    if (is_inv) nxt_kind = K_INVAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_kind  <= K_NONE;
      p_rsp   <= 1'b0;
      p_word  <= '0;
      p_off   <= '0;
      p_size  <= '0;
      p_wdata <= '0;
      p_cmp   <= '0;
      err_cmd <= 1'b0;
    end else begin
      p_kind <= nxt_kind;
      p_rsp  <= live && req_need_rsp && !is_bad;
      if (acc) begin
        p_word  <= r_word;
        p_off   <= r_off;
        p_size  <= req_size;
        p_wdata <= req_wdata;
        p_cmp   <= req_cmp;
      end
      if (is_bad) err_cmd <= 1'b1;
    end
  end

  // RAM read in the accept cycle
  assign ram_re    = is_rd || is_sw || cs_ok;
  assign ram_raddr = r_word;

  // compare and write in the cycle after acceptance
  assign old_val = pick(ram_q, p_size, p_off);
  assign cmp_hit = (old_val == (p_cmp & size_mask(p_size)));
  assign rmw_wr  = (p_kind == K_SWAP) || ((p_kind == K_CSWAP) && cmp_hit);

  // the two write sources never coincide: no request is accepted during rmw
  always_comb begin
    ram_we    = wr_go || rmw_wr;
    ram_waddr = r_word;
    ram_wbe   = lane_mask(req_size, r_off);
    ram_wdata = place(req_wdata, r_off);
    if (in_rmw) begin
      ram_waddr = p_word;
      ram_wbe   = lane_mask(p_size, p_off);
      ram_wdata = place(p_wdata, p_off);
    end
  end

  assign rsp_valid = p_rsp;
  assign rsp_err   = (p_kind == K_BADSZ);
  assign rsp_data  = ((p_kind == K_READ) || in_rmw) ? old_val : '0;
endmodule

// File: rtl/swap_mem_unit.sv
`timescale 1ns/1ps
module swap_mem_unit
  import smu_pkg::*;
#(
  parameter int AW   = 9,
  parameter int NREQ = 4,
  parameter int CW   = 16,
  parameter int BW   = 20,
  localparam int IDW  = $clog2(NREQ),
  localparam int IDXW = AW - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_cmd,
  input  logic [IDW-1:0]     req_id,
  input  logic [AW-1:0]      req_addr,
  input  logic [1:0]         req_size,
  input  logic [63:0]        req_wdata,
  input  logic [63:0]        req_cmp,
  input  logic               req_inhibit,
  input  logic               req_need_rsp,
  input  logic               req_ll,
  output logic               rsp_valid,
  output logic [63:0]        rsp_data,
  output logic               rsp_err,
  output logic               err_cmd,
  output logic               wr_chk_valid,
  output logic [IDW-1:0]     wr_chk_id,
  output logic [AW-1:0]      wr_chk_addr,
  input  logic               wr_chk_ok,
  output logic               ll_valid,
  output logic [IDW-1:0]     ll_id,
  output logic [AW-1:0]      ll_addr,
  output logic [NREQ*CW-1:0] cnt_rd,
  output logic [NREQ*CW-1:0] cnt_wr,
  output logic [NREQ*CW-1:0] cnt_oth,
  output logic [NREQ*BW-1:0] byt_rd,
  output logic [NREQ*BW-1:0] byt_wr
);
  // named internal events
  logic             acc, ev_rd, ev_wr, ev_oth;
  logic             ram_re, ram_we;
  logic [IDXW-1:0]  ram_raddr, ram_waddr;
  logic [LANES-1:0] ram_wbe;
  logic [DW-1:0]    ram_wdata, ram_q;

  assign wr_chk_id   = req_id;
  assign wr_chk_addr = req_addr;
  assign ll_id       = req_id;
  assign ll_addr     = req_addr;

  smu_ctrl #(.AW(AW), .IDXW(IDXW)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_cmp(req_cmp), .req_inhibit(req_inhibit), .req_need_rsp(req_need_rsp),
    .req_ll(req_ll), .wr_chk_ok(wr_chk_ok), .wr_chk_valid(wr_chk_valid),
    .ll_valid(ll_valid), .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_q(ram_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wbe(ram_wbe),
    .ram_wdata(ram_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .err_cmd(err_cmd), .acc(acc), .ev_rd(ev_rd),
    .ev_wr(ev_wr), .ev_oth(ev_oth)
  );

  smu_ram #(.IDXW(IDXW), .LANES(LANES)) i_ram (
    .clk(clk), .re(ram_re), .raddr(ram_raddr), .rdata(ram_q),
    .we(ram_we), .waddr(ram_waddr), .wbe(ram_wbe), .wdata(ram_wdata)
  );

  smu_counters #(.NREQ(NREQ), .IDW(IDW), .CW(CW), .BW(BW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .inc_rd(ev_rd), .inc_wr(ev_wr),
    .inc_oth(ev_oth), .id(req_id), .nbytes(size_bytes(req_size)),
    .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_oth(cnt_oth),
    .byt_rd(byt_rd), .byt_wr(byt_wr)
  );
endmodule

// File: rtl/smu_checker.sv
`timescale 1ns/1ps
module smu_checker
  import smu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       acc,
  input logic [2:0] req_cmd,
  input logic [1:0] req_size,
  input logic       req_inhibit,
  input logic       req_need_rsp,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       err_cmd,
  input logic       ll_valid,
  input logic       wr_chk_valid
);
  logic rmw_start, bad_size;
  assign rmw_start = acc && !req_inhibit &&
                     ((req_cmd == CMD_SWAP) || ((req_cmd == CMD_CSWAP) && req_size[1]));
  assign bad_size  = acc && !req_inhibit && req_need_rsp &&
                     (req_cmd == CMD_CSWAP) && !req_size[1];

  AST_RMW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> !req_ready); // R5
  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R5
  AST_RSP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && !req_inhibit && req_need_rsp)); // R11
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_inhibit) |-> (!wr_chk_valid && !ll_valid)); // R8
  AST_INHIBIT_NORSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_inhibit) |=> !rsp_valid); // R8
  AST_BADSIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_size |=> (rsp_valid && rsp_err)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |=> err_cmd); // R10
  AST_LL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ll_valid |-> (acc && (req_cmd == CMD_READ))); // R3
endmodule

bind swap_mem_unit smu_checker i_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .req_cmd(req_cmd),
  .req_size(req_size), .req_inhibit(req_inhibit), .req_need_rsp(req_need_rsp),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .err_cmd(err_cmd), .ll_valid(ll_valid), .wr_chk_valid(wr_chk_valid)
);

// File: tb/test_swap_mem_unit.sv
`timescale 1ns/1ps
module test_swap_mem_unit;
  localparam int CW = 16;
  localparam int BW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_inhibit = 1'b0, req_need_rsp = 1'b0, req_ll = 1'b0;
  logic [2:0]  req_cmd = '0;
  logic [1:0]  req_id = '0, req_size = '0;
  logic [8:0]  req_addr = '0;
  logic [63:0] req_wdata = '0, req_cmp = '0;
  logic wr_chk_ok = 1'b0;
  logic req_ready, rsp_valid, rsp_err, err_cmd, wr_chk_valid, ll_valid;
  logic [63:0] rsp_data;
  logic [1:0]  wr_chk_id, ll_id;
  logic [8:0]  wr_chk_addr, ll_addr;
  logic [4*CW-1:0] cnt_rd, cnt_wr, cnt_oth;
  logic [4*BW-1:0] byt_rd, byt_wr;

  swap_mem_unit i_swap_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_id(req_id), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_cmp(req_cmp), .req_inhibit(req_inhibit),
    .req_need_rsp(req_need_rsp), .req_ll(req_ll), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .err_cmd(err_cmd),
    .wr_chk_valid(wr_chk_valid), .wr_chk_id(wr_chk_id), .wr_chk_addr(wr_chk_addr),
    .wr_chk_ok(wr_chk_ok), .ll_valid(ll_valid), .ll_id(ll_id), .ll_addr(ll_addr),
    .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_oth(cnt_oth),
    .byt_rd(byt_rd), .byt_wr(byt_wr)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mdl [512];
  logic [15:0] m_rd [4], m_wr [4], m_oth [4];
  logic [19:0] m_brd [4], m_bwr [4];
  bit m_err = 0;

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] smask(input logic [1:0] s);
    return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * (1 << s))) - 64'd1);
  endfunction

  function automatic logic [63:0] mdl_get(input logic [8:0] a, input logic [1:0] s);
    logic [63:0] v = '0;
    for (int i = 0; i < (1 << s); i++) v[i*8 +: 8] = mdl[a + 9'(i)];
    return v;
  endfunction

  task automatic mdl_put(input logic [8:0] a, input logic [1:0] s, input logic [63:0] v);
    for (int i = 0; i < (1 << s); i++) mdl[a + 9'(i)] = v[i*8 +: 8];
  endtask

  task automatic check_counters();
    for (int g = 0; g < 4; g++) begin
      check(cnt_rd[g*CW +: CW] == m_rd[g], "R2 read count", 64'(cnt_rd[g*CW +: CW]), 64'(m_rd[g]));
      check(byt_rd[g*BW +: BW] == m_brd[g], "R2 read bytes", 64'(byt_rd[g*BW +: BW]), 64'(m_brd[g]));
      check(cnt_wr[g*CW +: CW] == m_wr[g], "R4 write count", 64'(cnt_wr[g*CW +: CW]), 64'(m_wr[g]));
      check(byt_wr[g*BW +: BW] == m_bwr[g], "R4 write bytes", 64'(byt_wr[g*BW +: BW]), 64'(m_bwr[g]));
      check(cnt_oth[g*CW +: CW] == m_oth[g], "R5 R6 other count", 64'(cnt_oth[g*CW +: CW]), 64'(m_oth[g]));
    end
  endtask

  task automatic op(input logic [2:0] cmd, input logic [1:0] id, input logic [8:0] addr,
                    input logic [1:0] sz, input logic [63:0] wd, input logic [63:0] cv,
                    input bit inh, input bit need, input bit ll, input bit ok_in);
    logic [63:0] old, expd;
    bit live, exp_rsp, exp_err, stall, cs_legal;
    old      = mdl_get(addr, sz);
    live     = !inh;
    cs_legal = (cmd == 3'd3) && sz[1];
    exp_rsp  = live && need && (cmd <= 3'd4);
    exp_err  = (cmd == 3'd3) && !sz[1];
    expd     = ((cmd == 3'd0) || (cmd == 3'd2) || cs_legal) ? old : 64'd0;
    stall    = live && ((cmd == 3'd2) || cs_legal);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = cmd; req_id = id; req_addr = addr; req_size = sz; req_wdata = wd;
    req_cmp = cv; req_inhibit = inh; req_need_rsp = need; req_ll = ll;
    wr_chk_ok = ok_in; req_valid = 1'b1;
    #1;
    check(wr_chk_valid == (live && cmd == 3'd1), "R4 R8 write check request",
          64'(wr_chk_valid), 64'(live && cmd == 3'd1));
    check(ll_valid == (live && cmd == 3'd0 && ll), "R3 R8 load-linked pulse",
          64'(ll_valid), 64'(live && cmd == 3'd0 && ll));
    if (live && cmd == 3'd1)
      check(wr_chk_addr == addr && wr_chk_id == id, "R4 write check fields",
            {53'd0, wr_chk_id, wr_chk_addr}, {53'd0, id, addr});
    if (live && cmd == 3'd0 && ll)
      check(ll_addr == addr && ll_id == id, "R3 reservation fields",
            {53'd0, ll_id, ll_addr}, {53'd0, id, addr});
    @(negedge clk);
    req_valid = 1'b0; req_inhibit = 1'b0; req_ll = 1'b0;
    check(rsp_valid == exp_rsp, "R11 R8 R10 response flag", 64'(rsp_valid), 64'(exp_rsp));
    if (exp_rsp) begin
      check(rsp_data == expd, "R2 R5 R6 R9 response data", rsp_data, expd);
      check(rsp_err == exp_err, "R7 size error flag", 64'(rsp_err), 64'(exp_err));
    end
    check(req_ready == !stall, "R5 R6 R7 stall cycle", 64'(req_ready), 64'(!stall));
    if (live) begin
      case (cmd)
        3'd0: begin m_rd[id]++; m_brd[id] += 20'(1 << sz); end
        3'd1: if (ok_in) begin mdl_put(addr, sz, wd); m_wr[id]++; m_bwr[id] += 20'(1 << sz); end
        3'd2: begin mdl_put(addr, sz, wd); m_oth[id]++; end
        3'd3: if (sz[1]) begin
                m_oth[id]++;
                if (old == (cv & smask(sz))) mdl_put(addr, sz, wd);
              end
        3'd4: ;
        default: m_err = 1;
      endcase
    end
    check(err_cmd == m_err, "R10 sticky command error", 64'(err_cmd), 64'(m_err));
    check_counters();
  endtask

  task automatic rd(input logic [8:0] a, input logic [1:0] s);
    op(3'd0, 2'd0, a, s, 64'd0, 64'd0, 0, 1, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] w, o;
    void'($urandom(32'd20240611));
    for (int g = 0; g < 4; g++) begin
      m_rd[g] = 0; m_wr[g] = 0; m_oth[g] = 0; m_brd[g] = 0; m_bwr[g] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    check(err_cmd == 1'b0, "R1 error clear after reset", 64'(err_cmd), 64'd0);
    check(cnt_rd == '0 && cnt_wr == '0 && cnt_oth == '0 && byt_rd == '0 && byt_wr == '0,
          "R1 counters clear", 64'(cnt_rd), 64'd0);

    // fill the memory with permitted 8-byte writes (R4)
    for (int i = 0; i < 64; i++)
      op(3'd1, 2'(i), 9'(i * 8), 2'd3, {$urandom, $urandom}, 64'd0, 0, 0, 0, 1);

    // R2 reads of every size at several offsets
    rd(9'd8, 2'd3); rd(9'd17, 2'd0); rd(9'd22, 2'd1); rd(9'd36, 2'd2); rd(9'd255, 2'd0);
    // R3 load-linked read from requester 2
    op(3'd0, 2'd2, 9'd64, 2'd2, 64'd0, 64'd0, 0, 1, 1, 0);
    // R4 refused write leaves memory alone; partial write keeps neighbours
    op(3'd1, 2'd1, 9'd40, 2'd3, 64'hDEAD_BEEF_0123_4567, 64'd0, 0, 1, 0, 0);
    rd(9'd40, 2'd3);
    op(3'd1, 2'd1, 9'd45, 2'd0, 64'h0000_0000_0000_00A5, 64'd0, 0, 1, 0, 1);
    rd(9'd40, 2'd3);
    // R5 swap then read back
    op(3'd2, 2'd3, 9'd80, 2'd2, 64'h0000_0000_CAFE_F00D, 64'd0, 0, 1, 0, 0);
    rd(9'd80, 2'd3);
    // R6 conditional swap hit (4 bytes) and miss (8 bytes)
    o = mdl_get(9'd96, 2'd2);
    op(3'd3, 2'd0, 9'd96, 2'd2, 64'h1122_3344, o, 0, 1, 0, 0);
    rd(9'd96, 2'd3);
    o = mdl_get(9'd104, 2'd3);
    op(3'd3, 2'd0, 9'd104, 2'd3, 64'h5566_7788_99AA_BBCC, ~o, 0, 1, 0, 0);
    rd(9'd104, 2'd3);
    // R7 short conditional swaps
    o = mdl_get(9'd112, 2'd0);
    op(3'd3, 2'd1, 9'd112, 2'd0, 64'h77, o, 0, 1, 0, 0);
    op(3'd3, 2'd1, 9'd114, 2'd1, 64'h7777, mdl_get(9'd114, 2'd1), 0, 1, 0, 0);
    rd(9'd112, 2'd3);
    // R8 inhibited write, swap and load-linked read
    op(3'd1, 2'd2, 9'd120, 2'd3, 64'h0, 64'd0, 1, 1, 0, 1);
    op(3'd2, 2'd2, 9'd120, 2'd3, 64'h0, 64'd0, 1, 1, 0, 0);
    op(3'd0, 2'd2, 9'd120, 2'd3, 64'h0, 64'd0, 1, 1, 1, 0);
    rd(9'd120, 2'd3);
    // R9 invalidate
    op(3'd4, 2'd3, 9'd128, 2'd3, 64'hFFFF, 64'd0, 0, 1, 0, 0);
    rd(9'd128, 2'd3);
    // R11 read without a response
    op(3'd0, 2'd1, 9'd136, 2'd3, 64'd0, 64'd0, 0, 0, 0, 0);
    // R10 unknown command, then check the memory it targeted
    op(3'd6, 2'd0, 9'd144, 2'd3, 64'h1234, 64'd0, 0, 1, 0, 1);
    rd(9'd144, 2'd3);

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic [2:0] c;
      logic [1:0] s;
      logic [8:0] a;
      int pick;
      pick = $urandom_range(0, 99);
      c = (pick < 30) ? 3'd0 : (pick < 55) ? 3'd1 : (pick < 72) ? 3'd2 :
          (pick < 90) ? 3'd3 : (pick < 96) ? 3'd4 : 3'(5 + $urandom_range(0, 2));
      s = 2'($urandom_range(0, 3));
      a = 9'($urandom_range(0, 511)) & ~9'((1 << s) - 1);
      w = {$urandom, $urandom};
      o = ($urandom_range(0, 1) == 1) ? mdl_get(a, s) : {$urandom, $urandom};
      op(c, 2'($urandom_range(0, 3)), a, s, w, o, ($urandom_range(0, 7) == 0),
         ($urandom_range(0, 5) != 0), ($urandom_range(0, 1) == 1), ($urandom_range(0, 3) != 0));
    end
    // sweep read back of the whole memory
    for (int i = 0; i < 64; i++) rd(9'(i * 8), 2'd3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule